// File: doc/BRIEF.md
# Amplifier Fault and Start-Up Supervisor

This block supervises one class-D amplifier channel pair. After the power-on reset is released it holds the outputs at high impedance for a fixed start-up interval. At the end of that interval it samples a 3-bit strap code, once only, and fixes the gain step and the clock-role, master or slave. Only after that can the output stage be driven.

Protection inputs fall into two classes. Overcurrent, overtemperature and DC-offset detection are latched: they pull the active-low fault line and put the outputs at high impedance until the shutdown input is taken low. Supply under- and overvoltage put the outputs at high impedance without touching the fault line, and release on their own once the supply is back in range. Taking the shutdown input low mutes the outputs and clears every latched fault. The captured role decides whether the shared PWM sync line is driven out or taken in.

Top module: `amp_supervisor`

## Requirements
- R1: The captured strap decodes as follows: bit 2 low gives master and bit 2 high gives slave (`role_slave`). Bits 1:0 give `gain_idx`, and `gain_db` is 20, 26, 32 or 36 for index 0, 1, 2 or 3.
- R2: `strap_valid` rises on the STARTUP_CYCLES-th rising clock edge after reset is released, and not before. The strap is sampled on that edge. Later strap changes have no effect on `gain_idx`, `gain_db` or `role_slave` until the next reset.
- R3: `out_mode` encodes 0 as high impedance, 1 as mute and 2 as drive. It stays 0 until `strap_valid` is high. With no fault and shutdown inactive, it becomes 2 on the edge after the one that raises `strap_valid`.
- R4: An overcurrent, overtemperature or DC-detect input sampled high while `shdn_n` is high causes three things on that edge: `fault_n` goes low, the matching `fault_cause` bit is set (bit 0 overcurrent, bit 1 overtemperature, bit 2 DC-detect) and `out_mode` becomes 0. All three hold after the input falls, for as long as `shdn_n` stays high.
- R5: Undervoltage or overvoltage sampled high sets `out_mode` to 0 on that edge and leaves `fault_n` high. `out_mode` returns to 2 on the first edge at which both inputs are low.
- R6: `shdn_n` sampled low clears `fault_cause` to 0 and sets `fault_n` high on that edge. It also sets `out_mode` to 1 once start-up is complete.
- R7: If a latched-fault input is still high on the edge at which `shdn_n` is first sampled high again, the latch sets on that same edge and `out_mode` never reaches 2.
- R8: Precedence runs as follows: start-up incomplete (0), then shutdown (1), then a latched fault (0), then a supply fault (0), then drive (2).
- R9: Before the strap is captured, `sync_oe` and `sync_out` are 0 and `pwm_clk` follows `pwm_ref`. In master role, `sync_oe` is 1 and both `sync_out` and `pwm_clk` follow `pwm_ref`. In slave role, `sync_oe` and `sync_out` are 0 and `pwm_clk` follows `sync_in`.
- R10: While reset is held low: `out_mode` is 0, `fault_n` is 1, `fault_cause` is 0, `strap_valid` is 0 and `sync_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Power-on reset, active low |
| shdn_n | input | 1 | Shutdown control, low mutes and clears latched faults |
| strap_code | input | 3 | Strap code from the gain/role converter |
| flt_ocp | input | 1 | Output overcurrent detected |
| flt_otp | input | 1 | Die overtemperature detected |
| flt_dc | input | 1 | Output DC offset detected |
| sup_uv | input | 1 | Supply below operating window |
| sup_ov | input | 1 | Supply above operating window |
| pwm_ref | input | 1 | Local PWM reference clock |
| sync_in | input | 1 | Sync line as seen at the pad |
| out_mode | output | 2 | Output stage command: 0 high-Z, 1 mute, 2 drive |
| fault_n | output | 1 | Latched fault indication, active low |
| fault_cause | output | 3 | Latched fault bits |
| strap_valid | output | 1 | Strap captured, start-up complete |
| role_slave | output | 1 | Captured role, 1 = slave |
| gain_idx | output | 2 | Captured gain step |
| gain_db | output | 6 | Captured gain in dB |
| sync_out | output | 1 | Sync line drive value |
| sync_oe | output | 1 | Sync line drive enable |
| pwm_clk | output | 1 | Selected PWM clock |

## Verification
The assertions assume that the protection and supply inputs are synchronous to `clk` and change only away from its rising edge. They also assume reset is held long enough that every register starts from its reset value. The bench drives every input just after a rising edge and samples one time unit later, so each input is seen by exactly one intended edge. The strap code is held steady across the capture edge and only changed afterwards, which stays within the assumption that the converter output has settled by the end of start-up.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;

   localparam int STRAP_W     = 3;
   localparam int GAIN_W      = STRAP_W - 1;
   localparam int GAIN_DB_W   = 6;
   localparam int NUM_LATCHED = 3;

   localparam int LF_OCP = 0;
   localparam int LF_OTP = 1;
   localparam int LF_DC  = 2;

   typedef enum logic [1:0] {
      OM_HIZ   = 2'd0,
      OM_MUTE  = 2'd1,
      OM_DRIVE = 2'd2
   } out_mode_e;

   typedef struct packed {
      logic              slave;
      logic [GAIN_W-1:0] gain_idx;
   } strap_t;

   function automatic logic [GAIN_DB_W-1:0] gain_db_of(input logic [GAIN_W-1:0] idx);
      logic [GAIN_DB_W-1:0] db;
      case (idx)
         2'd0:    db = 6'd20;
         2'd1:    db = 6'd26;
         2'd2:    db = 6'd32;
         default: db = 6'd36;
      endcase
      return db;
   endfunction

endpackage

// File: rtl/amp_startup_timer.sv
module amp_startup_timer
   import amp_sup_pkg::*;
#(
   parameter int STARTUP_CYCLES = 1_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_code,
   output logic               done,
   output strap_t             strap_q
);

   localparam int CNT_W = (STARTUP_CYCLES > 2) ? $clog2(STARTUP_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYCLES - 1);

   if (STARTUP_CYCLES < 2) begin : g_bad_startup
      $error("STARTUP_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         done_q  <= 1'b0;
         strap_q <= '0;
      end else if (!done_q) begin
         if (cnt_q == LAST) begin
            done_q  <= 1'b1;
            strap_q <= strap_t'(strap_code);
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign done = done_q;

endmodule

// File: rtl/amp_fault_latch.sv
module amp_fault_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set_in,
   output logic [N-1:0] latch_nxt,
   output logic [N-1:0] latch_q
);

   if (N < 1) begin : g_bad_n
      $error("fault latch needs at least one input");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic bit_q;

      assign latch_nxt[i] = clr ? 1'b0 : (bit_q | set_in[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= latch_nxt[i];
      end

      assign latch_q[i] = bit_q;
   end

endmodule

// File: rtl/amp_sync_mux.sv
module amp_sync_mux (
   input  logic role_valid,
   input  logic role_slave,
   input  logic pwm_ref,
   input  logic sync_in,
   output logic sync_out,
   output logic sync_oe,
   output logic pwm_clk
);

   logic drive_master;

   assign drive_master = role_valid & ~role_slave;
   assign sync_oe      = drive_master;
   assign sync_out     = drive_master & pwm_ref;
   assign pwm_clk      = (role_valid & role_slave) ? sync_in : pwm_ref;

endmodule

// File: rtl/amp_supervisor.sv
module amp_supervisor
   import amp_sup_pkg::*;
#(
   parameter int STARTUP_CYCLES = 1_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shdn_n,
   input  logic [STRAP_W-1:0]   strap_code,
   input  logic                 flt_ocp,
   input  logic                 flt_otp,
   input  logic                 flt_dc,
   input  logic                 sup_uv,
   input  logic                 sup_ov,
   input  logic                 pwm_ref,
   input  logic                 sync_in,
   output logic [1:0]           out_mode,
   output logic                 fault_n,
   output logic [NUM_LATCHED-1:0] fault_cause,
   output logic                 strap_valid,
   output logic                 role_slave,
   output logic [GAIN_W-1:0]    gain_idx,
   output logic [GAIN_DB_W-1:0] gain_db,
   output logic                 sync_out,
   output logic                 sync_oe,
   output logic                 pwm_clk
);

   logic                   started;
   strap_t                 strap_q;
   logic [NUM_LATCHED-1:0] set_vec;
   logic [NUM_LATCHED-1:0] latch_nxt;
   logic [NUM_LATCHED-1:0] latch_q;
   logic                   shut;
   logic                   supply_bad;
   out_mode_e              mode_nxt;
   out_mode_e              mode_q;

   amp_startup_timer #(
      .STARTUP_CYCLES(STARTUP_CYCLES)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_code(strap_code),
      .done      (started),
      .strap_q   (strap_q)
   );

   always_comb begin
      set_vec         = '0;
      set_vec[LF_OCP] = flt_ocp;
      set_vec[LF_OTP] = flt_otp;
      set_vec[LF_DC]  = flt_dc;
   end

   assign shut       = ~shdn_n;
   assign supply_bad = sup_uv | sup_ov;

   amp_fault_latch #(
      .N(NUM_LATCHED)
   ) i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (shut),
      .set_in   (set_vec),
      .latch_nxt(latch_nxt),
      .latch_q  (latch_q)
   );

   always_comb begin
      if (!started)          mode_nxt = OM_HIZ;
      else if (shut)         mode_nxt = OM_MUTE;
      else if (|latch_nxt)   mode_nxt = OM_HIZ;
      else if (supply_bad)   mode_nxt = OM_HIZ;
      else                   mode_nxt = OM_DRIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= OM_HIZ;
      else        mode_q <= mode_nxt;
   end

   assign out_mode    = mode_q;
   assign fault_cause = latch_q;
   assign fault_n     = ~(|latch_q);
   assign strap_valid = started;
   assign role_slave  = strap_q.slave;
   assign gain_idx    = strap_q.gain_idx;
   assign gain_db     = gain_db_of(strap_q.gain_idx);

   amp_sync_mux i_sync (
      .role_valid(started),
      .role_slave(strap_q.slave),
      .pwm_ref   (pwm_ref),
      .sync_in   (sync_in),
      .sync_out  (sync_out),
      .sync_oe   (sync_oe),
      .pwm_clk   (pwm_clk)
   );

endmodule

// File: rtl/amp_supervisor_chk.sv
module amp_supervisor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       shdn_n,
   input logic       flt_ocp,
   input logic       flt_otp,
   input logic       flt_dc,
   input logic       sup_uv,
   input logic       sup_ov,
   input logic [1:0] out_mode,
   input logic       fault_n,
   input logic [2:0] fault_cause,
   input logic       strap_valid,
   input logic       role_slave,
   input logic [1:0] gain_idx,
   input logic       sync_oe
);

   // R4: a latched-fault input seen with shutdown inactive asserts the fault line
   a_r4_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_n && (flt_ocp || flt_otp || flt_dc)) |=> !fault_n);

   // R4: a latched bit only falls when shutdown was low on the clearing edge
   a_r4_clear_needs_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(fault_cause) & ~fault_cause)) |-> !$past(shdn_n));

   // R5: supply window faults never leave the stage driving
   a_r5_supply_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_uv || sup_ov) |=> (out_mode != 2'd2));

   // R6: shutdown clears the latches on the next edge
   a_r6_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> (fault_n && (fault_cause == 3'd0)));

   // R2: captured strap stays put once valid
   a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_valid && $past(strap_valid)) |-> ($stable(gain_idx) && $stable(role_slave)));

   // R3: never driving before start-up completes
   a_r3_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_valid |-> (out_mode == 2'd0));

   // R8: an active fault line excludes driving
   a_r8_fault_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> (out_mode != 2'd2));

   // R9: slave role never drives the sync line
   a_r9_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_valid && role_slave) |-> !sync_oe);

endmodule

bind amp_supervisor amp_supervisor_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .shdn_n     (shdn_n),
   .flt_ocp    (flt_ocp),
   .flt_otp    (flt_otp),
   .flt_dc     (flt_dc),
   .sup_uv     (sup_uv),
   .sup_ov     (sup_ov),
   .out_mode   (out_mode),
   .fault_n    (fault_n),
   .fault_cause(fault_cause),
   .strap_valid(strap_valid),
   .role_slave (role_slave),
   .gain_idx   (gain_idx),
   .sync_oe    (sync_oe)
);

// File: tb/test_amp_supervisor.sv
module test_amp_supervisor;

   localparam int CLK_PERIOD = 10;
   localparam int N_START    = 16;
   localparam int HIZ = 0, MUTE = 1, DRIVE = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shdn_n = 1'b1;
   logic [2:0] strap_code = 3'd0;
   logic       flt_ocp = 1'b0, flt_otp = 1'b0, flt_dc = 1'b0;
   logic       sup_uv = 1'b0, sup_ov = 1'b0;
   logic       pwm_ref = 1'b0, sync_in = 1'b0;
   logic [1:0] out_mode;
   logic       fault_n;
   logic [2:0] fault_cause;
   logic       strap_valid, role_slave;
   logic [1:0] gain_idx;
   logic [5:0] gain_db;
   logic       sync_out, sync_oe, pwm_clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   amp_supervisor #(.STARTUP_CYCLES(N_START)) i_amp_supervisor (
      .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .strap_code(strap_code),
      .flt_ocp(flt_ocp), .flt_otp(flt_otp), .flt_dc(flt_dc),
      .sup_uv(sup_uv), .sup_ov(sup_ov), .pwm_ref(pwm_ref), .sync_in(sync_in),
      .out_mode(out_mode), .fault_n(fault_n), .fault_cause(fault_cause),
      .strap_valid(strap_valid), .role_slave(role_slave), .gain_idx(gain_idx),
      .gain_db(gain_db), .sync_out(sync_out), .sync_oe(sync_oe), .pwm_clk(pwm_clk)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] code, input logic sd);
      rst_n = 1'b0; shdn_n = sd; strap_code = code;
      flt_ocp = 0; flt_otp = 0; flt_dc = 0; sup_uv = 0; sup_ov = 0;
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   task automatic cycle_shutdown();
      shdn_n = 1'b0; tick();
      shdn_n = 1'b1; tick();
   endtask

   initial begin
      // reset state
      do_reset(3'd0, 1'b1);
      rst_n = 1'b0; #1;
      check("R10 out_mode", out_mode, HIZ);
      check("R10 fault_n", fault_n, 1);
      check("R10 fault_cause", fault_cause, 0);
      check("R10 strap_valid", strap_valid, 0);
      check("R10 sync_oe", sync_oe, 0);

      // sweep all strap codes
      for (int code = 0; code < 8; code++) begin
         automatic int exp_idx = code % 4;
         automatic int exp_db  = (exp_idx == 3) ? 36 : 20 + 6 * exp_idx;
         automatic int exp_sl  = code / 4;
         do_reset(3'(code), 1'b1);
         repeat (N_START - 1) tick();
         check("R2 not yet valid", strap_valid, 0);
         check("R3 hiz during start-up", out_mode, HIZ);
         pwm_ref = 1'b1; sync_in = 1'b0; #1;
         check("R9 pre-capture pwm_clk", pwm_clk, 1);
         check("R9 pre-capture sync_oe", sync_oe, 0);
         tick();
         check("R2 valid at capture edge", strap_valid, 1);
         check("R3 hiz on capture edge", out_mode, HIZ);
         check("R1 role", role_slave, exp_sl);
         check("R1 gain_idx", gain_idx, exp_idx);
         check("R1 gain_db", gain_db, exp_db);
         strap_code = ~3'(code);
         tick();
         check("R3 drive after start-up", out_mode, DRIVE);
         tick();
         check("R2 strap change ignored idx", gain_idx, exp_idx);
         check("R2 strap change ignored role", role_slave, exp_sl);
         check("R2 strap change ignored db", gain_db, exp_db);
         pwm_ref = 1'b1; sync_in = 1'b0; #1;
         check("R9 pwm_clk a", pwm_clk, exp_sl ? 0 : 1);
         check("R9 sync_out a", sync_out, exp_sl ? 0 : 1);
         check("R9 sync_oe", sync_oe, exp_sl ? 0 : 1);
         pwm_ref = 1'b0; sync_in = 1'b1; #1;
         check("R9 pwm_clk b", pwm_clk, exp_sl ? 1 : 0);
         check("R9 sync_out b", sync_out, 0);
      end

      // latched faults, each class
      for (int f = 0; f < 3; f++) begin
         flt_ocp = (f == 0); flt_otp = (f == 1); flt_dc = (f == 2);
         tick();
         check("R4 fault_n low", fault_n, 0);
         check("R4 cause bit", fault_cause, 1 << f);
         check("R4 hiz", out_mode, HIZ);
         flt_ocp = 0; flt_otp = 0; flt_dc = 0;
         repeat (3) tick();
         check("R4 held fault_n", fault_n, 0);
         check("R4 held hiz", out_mode, HIZ);
         shdn_n = 1'b0; tick();
         check("R6 fault cleared", fault_n, 1);
         check("R6 cause cleared", fault_cause, 0);
         check("R6 mute", out_mode, MUTE);
         shdn_n = 1'b1; tick();
         check("R6 drive after release", out_mode, DRIVE);
      end

      // re-latch on release while fault persists
      shdn_n = 1'b0; flt_otp = 1'b1; tick();
      check("R8 shutdown over latched: mute", out_mode, MUTE);
      check("R8 shutdown over latched: fault_n", fault_n, 1);
      shdn_n = 1'b1; tick();
      check("R7 relatch fault_n", fault_n, 0);
      check("R7 relatch cause", fault_cause, 2);
      check("R7 no drive", out_mode, HIZ);
      flt_otp = 1'b0; tick();
      check("R7 still latched", out_mode, HIZ);
      cycle_shutdown();
      check("R6 recovered", out_mode, DRIVE);

      // supply window faults
      sup_uv = 1'b1; tick();
      check("R5 uv hiz", out_mode, HIZ);
      check("R5 uv fault_n", fault_n, 1);
      sup_uv = 1'b0; tick();
      check("R5 uv self-clear", out_mode, DRIVE);
      sup_ov = 1'b1; tick();
      check("R5 ov hiz", out_mode, HIZ);
      check("R5 ov cause", fault_cause, 0);
      sup_ov = 1'b0; tick();
      check("R5 ov self-clear", out_mode, DRIVE);

      // precedence
      shdn_n = 1'b0; sup_uv = 1'b1; tick();
      check("R8 shutdown over supply", out_mode, MUTE);
      shdn_n = 1'b1; tick();
      check("R8 supply after release", out_mode, HIZ);
      flt_ocp = 1'b1; tick();
      check("R8 latched with supply fault_n", fault_n, 0);
      flt_ocp = 1'b0; sup_uv = 1'b0; tick();
      check("R8 latched outlives supply", out_mode, HIZ);
      check("R4 latched not self-clearing", fault_n, 0);
      cycle_shutdown();
      check("R8 recovered", out_mode, DRIVE);

      // start-up precedence over shutdown
      do_reset(3'd2, 1'b0);
      repeat (N_START) tick();
      check("R8 start-up over shutdown", out_mode, HIZ);
      tick();
      check("R8 shutdown after start-up", out_mode, MUTE);
      shdn_n = 1'b1; tick();
      check("R3 drive after shutdown release", out_mode, DRIVE);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule